// File: doc/BRIEF.md
# Overwriting Character Ring Buffer

This block is a byte-wide circular queue with a live fill count, sized for the receive and transmit queues of a serial-port register model. A producer pushes bytes and a consumer pops them. The byte at the head of the queue is always visible on the data output, so a pop collects it in the same cycle that the pop is asserted. A synchronous clear empties the queue.

The queue never stalls its producer. A push into a full queue stores the new byte in place of the oldest one, so the most recent characters are always the ones kept. A pop from an empty queue returns the filler value 0xFF and leaves the queue as it was. The depth is a parameter and need not be a power of two. The default depth is 6, which tests the index wrap at a boundary that is not a power of two.

Top module: `char_ring`

## Requirements
- R1: After reset the count output is 0 and the data output shows 0xFF.
- R2: A push with no pop, when count is below DEPTH, increases count by one, and bytes leave the queue in the order they were pushed.
- R3: A push with no pop into a full queue leaves count at DEPTH and discards the oldest byte, so the head becomes the second-oldest byte.
- R4: With count nonzero, the data output shows the oldest stored byte in the same cycle, and a pop with no push lowers count by one.
- R5: With count at 0 the data output is 0xFF, and a pop with no push leaves count at 0.
- R6: A clear sets count to 0 on the next edge and takes precedence over a push or pop in the same cycle. The byte pushed in that cycle is not stored.
- R7: Push and pop in one cycle on a queue that is neither empty nor full leave count unchanged and keep the order of the bytes.
- R8: Push and pop in one cycle on an empty queue return 0xFF and leave count at 1, with the pushed byte at the head.
- R9: Push and pop in one cycle on a full queue return the oldest byte and leave count at DEPTH, with the new byte at the tail.
- R10: Count never exceeds DEPTH, and the order is kept across many wraps of the indices at a depth that is not a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of the queue |
| push | input | 1 | Store pushData at the tail |
| pushData | input | 8 | Byte to store |
| pop | input | 1 | Remove the head byte |
| popData | output | 8 | Head byte, or 0xFF when empty |
| count | output | $clog2(DEPTH+1) | Number of stored bytes |

## Verification
Push and pop can fall in the same cycle, and how they combine depends on whether the queue is empty, partly filled or full. The bench drives both strobes together in each of those three fill states. It also sends clear together with push and pop. A behavioural queue model in the bench predicts the head byte and the count every cycle. The outputs are compared against this model before each edge, both in the directed phases and in a long pseudo-random run that wraps the indices many times.

// File: rtl/char_ring_pkg.sv
package char_ring_pkg;
  typedef struct packed {
    logic clr;
    logic wrEn;
    logic wrAdv;
    logic rdAdv;
    logic cntInc;
    logic cntDec;
  } ringStrobe_t;
endpackage

// File: rtl/char_ring_ctrl.sv
module char_ring_ctrl
  import char_ring_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             push,
  input  logic             pop,
  input  logic [CNT_W-1:0] count,
  output ringStrobe_t      strobe
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

  logic isEmpty, isFull, popTaken;

  assign isEmpty  = (count == '0);
  assign isFull   = (count == CAP);
  assign popTaken = pop && !isEmpty;

  always_comb begin
    strobe.clr    = clear;
    strobe.wrEn   = push && !clear;
    strobe.wrAdv  = push && !clear;
    // one head step covers both a real pop and an overwrite on full
    strobe.rdAdv  = !clear && (popTaken || (push && isFull));
    strobe.cntInc = !clear && push && !isFull && !popTaken;
    strobe.cntDec = !clear && popTaken && !push;
  end

  a_r2_push_inc: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop && !clear && count < CAP) |=> (count == $past(count) + CNT_W'(1)));
  a_r3_full_hold: assert property (@(posedge clk) disable iff (!rstN)
    (push && !clear && isFull) |=> (count == CAP));
  a_r4_pop_dec: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !push && !clear && !isEmpty) |=> (count == $past(count) - CNT_W'(1)));
  a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !push && !clear && isEmpty) |=> (count == '0));
  a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (count == '0));
  a_r7_both_same: assert property (@(posedge clk) disable iff (!rstN)
    (push && pop && !clear && !isEmpty) |=> (count == $past(count)));
  a_r8_both_empty: assert property (@(posedge clk) disable iff (!rstN)
    (push && pop && !clear && isEmpty) |=> (count == CNT_W'(1)));
endmodule

// File: rtl/char_ring_dp.sv
module char_ring_dp
  import char_ring_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int IDX_W = 3,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ringStrobe_t      strobe,
  input  logic [7:0]       pushData,
  output logic [7:0]       popData,
  output logic [CNT_W-1:0] count
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);
  localparam logic [7:0]       FILL = 8'hFF;

  logic [7:0]       mem [DEPTH];
  logic [IDX_W-1:0] rdIdx, wrIdx;
  logic [CNT_W-1:0] cnt;

  function automatic logic [IDX_W-1:0] stepIdx(input logic [IDX_W-1:0] i);
    return (i == LAST) ? '0 : i + IDX_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[wrIdx] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdIdx <= '0;
      wrIdx <= '0;
      cnt   <= '0;
    end else if (strobe.clr) begin
      rdIdx <= '0;
      wrIdx <= '0;
      cnt   <= '0;
    end else begin
      if (strobe.wrAdv)  wrIdx <= stepIdx(wrIdx);
      if (strobe.rdAdv)  rdIdx <= stepIdx(rdIdx);
      if (strobe.cntInc) cnt   <= cnt + CNT_W'(1);
      else if (strobe.cntDec) cnt <= cnt - CNT_W'(1);
    end
  end

  assign popData = (cnt == '0) ? FILL : mem[rdIdx];
  assign count   = cnt;

  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CAP);
  a_r10_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdx <= LAST) && (wrIdx <= LAST));
  a_r10_idx_gap: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0 || cnt == CAP) |-> (rdIdx == wrIdx));
endmodule

// File: rtl/char_ring.sv
module char_ring
  import char_ring_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             push,
  input  logic [7:0]       pushData,
  input  logic             pop,
  output logic [7:0]       popData,
  output logic [CNT_W-1:0] count
);
  ringStrobe_t strobe;

  char_ring_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .clear(clear), .push(push), .pop(pop),
    .count(count), .strobe(strobe)
  );

  char_ring_dp #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pushData(pushData),
    .popData(popData), .count(count)
  );
endmodule

// File: tb/char_ring_tb_top.sv
module char_ring_tb_top;
  localparam int DEPTH = 6;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clear = 1'b0, push = 1'b0, pop = 1'b0;
  logic [7:0] pushData = 8'h00;
  logic [7:0] popData;
  logic [CNT_W-1:0] count;

  int checks = 0;
  int errors = 0;
  logic [7:0] model[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  char_ring #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .clear(clear), .push(push), .pushData(pushData),
    .pop(pop), .popData(popData), .count(count)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit c, input bit pu, input logic [7:0] d, input bit po);
    int expHead;
    @(negedge clk);
    clear = c; push = pu; pushData = d; pop = po;
    #1;
    expHead = (model.size() > 0) ? int'(model[0]) : 8'hFF;
    check(tag, int'(count), model.size(), "count");
    check(tag, int'(popData), expHead, "popData");
    @(posedge clk);
    if (c) model.delete();
    else begin
      if (po && model.size() > 0) void'(model.pop_front());
      if (pu) begin
        if (model.size() == DEPTH) void'(model.pop_front());
        model.push_back(d);
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int seed;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", int'(count), 0, "count");
    check("R1", int'(popData), 8'hFF, "popData");
    @(negedge clk);
    rstN = 1'b1;
    // R5 pop on empty
    for (int i = 0; i < 3; i++) step("R5", 0, 0, 8'h00, 1);
    // R2 plain pushes
    for (int i = 0; i < 4; i++) step("R2", 0, 1, 8'h10 + 8'(i), 0);
    // R4 pops with head shown combinationally
    for (int i = 0; i < 2; i++) step("R4", 0, 0, 8'h00, 1);
    // R7 push and pop together, partly filled
    for (int i = 0; i < 5; i++) step("R7", 0, 1, 8'h20 + 8'(i), 1);
    // R3 fill and overwrite the oldest
    for (int i = 0; i < 8; i++) step("R3", 0, 1, 8'h30 + 8'(i), 0);
    step("R3", 0, 0, 8'h00, 0);
    // R9 push and pop together when full
    for (int i = 0; i < 3; i++) step("R9", 0, 1, 8'h40 + 8'(i), 1);
    step("R9", 0, 0, 8'h00, 0);
    // R6 clear wins over push and pop
    step("R6", 1, 1, 8'h55, 1);
    step("R6", 0, 0, 8'h00, 0);
    step("R6", 0, 1, 8'h66, 0);
    step("R6", 1, 0, 8'h00, 0);
    // R8 push and pop together on empty
    step("R8", 0, 1, 8'h77, 1);
    step("R8", 0, 0, 8'h00, 0);
    step("R8", 0, 0, 8'h00, 1);
    // R10 long mixed traffic, many wraps
    seed = 32'h1234_5678;
    for (int i = 0; i < 600; i++) begin
      seed = seed * 1103515245 + 12345;
      step("R10", (seed[27:22] == 6'd0), seed[17], 8'(seed[31:24]), seed[19] & seed[20]);
    end
    step("R10", 0, 0, 8'h00, 0);
    finish_run();
  end
endmodule